// File: doc/BRIEF.md
# Audio Master Clock Ratio Divider

This block derives an audio master clock from a fast root clock. The root clock is fed to the block at twice the highest ratio of one of two families. In the 512 family it runs at 1024 times the sample rate fs. In the 384 family it runs at 768·fs. A free-running phase counter spans exactly one sample period: 1024 root cycles in the 512 family and 768 in the 384 family. The master clock is one bit of that counter, so every ratio has a 50 % duty cycle. A three-bit exponent selects which bit is used, and that choice sets the power-of-two sub-rate within the family.

Besides the master clock, the block gives the serial port two single-cycle pulses. The bit-clock enable fires once every 16 root cycles, which is 64·fs or 48·fs. The frame strobe fires once per sample period. A control setting is sampled only when the phase counter is at its final count, so the outputs never show a shortened pulse. An illegal exponent silences all three outputs and raises an error flag. The block works for sample rates from 8 kHz to 192 kHz as long as the root clock follows them.

Top module: `mclk_ratio_div`

## Requirements
- R1: While reset is high and in the first cycle after it, `mclk_o`, `bclk_en_o`, `frame_o` and `cfg_err_o` are 0. The active setting after reset is disabled, family 512, exponent 0, and the phase counter is 0.
- R2: With `base_sel_i`=0 (512 family) and exponent m in 0..4, `mclk_o` equals bit m of the phase counter. It is low for 2^m root cycles and then high for 2^m root cycles, giving an MCLK of (512>>m)·fs.
- R3: With `base_sel_i`=1 (384 family) and exponent m in 0..3, `mclk_o` equals bit m of the phase counter, giving an MCLK of (384>>m)·fs, with the counter counting modulo 768.
- R4: If the adopted setting has `run_i`=0 or `gate_i`=1, then `mclk_o`, `bclk_en_o` and `frame_o` stay low.
- R5: Some exponents are illegal: any value of 5 or more in either family, and 4 in the 384 family. While an illegal exponent is adopted, `cfg_err_o` is 1 and `mclk_o`, `bclk_en_o` and `frame_o` stay low.
- R6: `run_i`, `gate_i`, `base_sel_i` and `mult_i` are sampled only on the clock edge where the phase counter sits at its last value. Changes at any other time have no effect until then.
- R7: While enabled and legal, `bclk_en_o` is high for one cycle whenever the four low counter bits are all ones, which is every 16 root cycles.
- R8: While enabled and legal, `frame_o` is high for the one cycle in which the counter holds its last value: 1023 in the 512 family, 767 in the 384 family.
- R9: The phase counter runs freely from reset, whatever the setting, and wraps to 0 after the last value of the adopted family.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Root clock, 1024·fs or 768·fs |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Request to drive the outputs |
| gate_i | input | 1 | Clock gate, 1 silences the outputs |
| base_sel_i | input | 1 | Family: 0 = 512, 1 = 384 |
| mult_i | input | 3 | Power-of-two sub-rate exponent |
| mclk_o | output | 1 | Audio master clock |
| bclk_en_o | output | 1 | One-cycle bit-clock-rate pulse |
| frame_o | output | 1 | One-cycle pulse per sample period |
| cfg_err_o | output | 1 | Adopted exponent is illegal |

## Verification
The assertions assume that reset is held high from time zero through at least one clock edge. They also assume the control inputs are valid levels at every rising edge. The bench changes its inputs only on falling edges, so every rising edge sees stable values. Some control changes are deliberately placed in the middle of a sample period. The bench's per-cycle reference then has to keep the old setting until the counter reaches its last value.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;

    localparam int PHASE_W  = 10;  // counter spans one sample period
    localparam int MULT_W   = 3;
    localparam int MAX_M512 = 4;
    localparam int MAX_M384 = 3;
    localparam int BCLK_LSB = 4;   // bit-clock enable every 2**BCLK_LSB cycles

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [MULT_W-1:0]  mult_t;

    typedef enum logic {
        FAM_512 = 1'b0,
        FAM_384 = 1'b1
    } family_e;

    typedef struct packed {
        logic    enable;
        family_e family;
        mult_t   mult;
    } ratio_cfg_t;

    localparam ratio_cfg_t CFG_RESET = '{enable: 1'b0, family: FAM_512, mult: '0};

    function automatic phase_t phase_last(input family_e fam);
        phase_t v;
        if (fam == FAM_384) v = phase_t'((3 << (PHASE_W - 2)) - 1);
        else                v = '1;
        return v;
    endfunction

    function automatic logic cfg_illegal(input ratio_cfg_t c);
        int lim;
        lim = (c.family == FAM_384) ? MAX_M384 : MAX_M512;
        return int'(c.mult) > lim;
    endfunction

endpackage

// File: rtl/mclk_phase_ctr.sv
module mclk_phase_ctr
    import mclk_div_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  phase_t last_i,
    output phase_t cnt_o,
    output logic   wrap_o
);

    assign wrap_o = (cnt_o == last_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_o <= '0;
        else if (wrap_o) cnt_o <= '0;
        else             cnt_o <= cnt_o + phase_t'(1);
    end

    // R9
    phase_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> (cnt_o == '0));

endmodule

// File: rtl/mclk_cfg_shadow.sv
module mclk_cfg_shadow
    import mclk_div_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wrap_i,
    input  ratio_cfg_t req_i,
    output ratio_cfg_t act_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i)       act_o <= CFG_RESET;
        else if (wrap_i) act_o <= req_i;
    end

    // R6
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> $stable(act_o));

endmodule

// File: rtl/mclk_ratio_div.sv
module mclk_ratio_div
    import mclk_div_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       run_i,
    input  logic       gate_i,
    input  logic       base_sel_i,
    input  logic [2:0] mult_i,
    output logic       mclk_o,
    output logic       bclk_en_o,
    output logic       frame_o,
    output logic       cfg_err_o
);

    ratio_cfg_t req, act;
    phase_t     cnt, last;
    logic       wrap, live;

    always_comb begin
        req.enable = run_i & ~gate_i;
        req.family = family_e'(base_sel_i);
        req.mult   = mult_t'(mult_i);
    end

    assign last = phase_last(act.family);

    mclk_phase_ctr i_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .last_i (last),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    mclk_cfg_shadow i_shadow (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wrap_i (wrap),
        .req_i  (req),
        .act_o  (act)
    );

    assign cfg_err_o = cfg_illegal(act);
    assign live      = act.enable & ~cfg_err_o;
    assign mclk_o    = live & cnt[act.mult];
    assign bclk_en_o = live & (&cnt[BCLK_LSB-1:0]);
    assign frame_o   = live & wrap;

    // R5
    err_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_err_o |-> (!mclk_o && !bclk_en_o && !frame_o));

    // R8
    frame_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_o |=> (cnt == '0));

    // R7
    bclk_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bclk_en_o |=> !bclk_en_o);

    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !act.enable |-> (!mclk_o && !frame_o));

endmodule

// File: tb/test_mclk_ratio_div.sv
module test_mclk_ratio_div;

    typedef struct packed {
        logic mclk;
        logic bclk;
        logic frame;
        logic err;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0, gate = 1'b0, base_sel = 1'b0;
    logic [2:0] mult = 3'd0;
    logic mclk, bclk_en, frame, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t expq[$];

    always #2 clk = ~clk;   // 250 MHz

    mclk_ratio_div i_mclk_ratio_div (
        .clk_i(clk), .rst_i(rst), .run_i(run), .gate_i(gate),
        .base_sel_i(base_sel), .mult_i(mult),
        .mclk_o(mclk), .bclk_en_o(bclk_en), .frame_o(frame), .cfg_err_o(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: pushes the expected outputs after each edge
    int m_cnt = 0, m_mult = 0;
    bit m_en = 0, m_base = 0;
    always @(posedge clk) begin
        exp_t e;
        bit bad, ok;
        int last;
        if (rst) begin
            m_cnt = 0; m_en = 0; m_base = 0; m_mult = 0;
        end else begin
            last = m_base ? 767 : 1023;
            if (m_cnt == last) begin
                m_cnt = 0; m_en = run && !gate; m_base = base_sel; m_mult = int'(mult);
            end else m_cnt++;
        end
        bad = (m_mult > 4) || (m_mult == 4 && m_base);
        ok  = m_en && !bad;
        e.mclk  = ok && m_cnt[m_mult];
        e.bclk  = ok && ((m_cnt % 16) == 15);
        e.frame = ok && (m_cnt == (m_base ? 767 : 1023));
        e.err   = bad;
        expq.push_back(e);
    end

    // monitor
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check(mclk    == e.mclk,  "R2/R3/R4 mclk", mclk, e.mclk);
            check(bclk_en == e.bclk,  "R7 bclk_en",    bclk_en, e.bclk);
            check(frame   == e.frame, "R8 frame",      frame, e.frame);
            check(cfg_err == e.err,   "R5 cfg_err",    cfg_err, e.err);
        end
    end

    task automatic setcfg(input bit r, input bit g, input bit b, input int m, input int cycles);
        @(negedge clk);
        run = r; gate = g; base_sel = b; mult = 3'(m);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({mclk, bclk_en, frame, cfg_err} == 4'b0, "R1 reset outputs",
              {mclk, bclk_en, frame, cfg_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({mclk, bclk_en, frame, cfg_err} == 4'b0, "R1 after release",
              {mclk, bclk_en, frame, cfg_err}, 0);
        // R6: request made mid-frame, adopted only at the wrap
        setcfg(1, 0, 0, 0, 2100);   // R2 m=0
        setcfg(1, 0, 0, 2, 2100);   // R2 m=2
        setcfg(1, 0, 0, 4, 2100);   // R2 m=4
        setcfg(1, 0, 1, 0, 2100);   // R3 m=0, R9 modulus 768
        setcfg(1, 0, 1, 3, 2100);   // R3 m=3
        setcfg(1, 0, 1, 4, 2100);   // R5 illegal in 384 family
        setcfg(1, 0, 0, 6, 2100);   // R5 illegal in 512 family
        setcfg(1, 1, 0, 1, 2100);   // R4 gate set
        setcfg(0, 0, 1, 1, 2100);   // R4 run clear
        setcfg(1, 0, 0, 1, 300);    // R6 change part way through
        setcfg(1, 0, 1, 2, 1900);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule